// File: doc/BRIEF.md
# Wrap-Aware Timed Event Queue

This block holds a bounded set of pending timed events. Each event pairs a small type code with a 32-bit target count. The block keeps the events sorted by how soon each falls due, measured against a free-running count that arrives on an input. Because ordering uses the unsigned modular distance from that live count, targets that wrap past 2^32 still sort ahead of or behind the others correctly. The earliest event is always shown on the head outputs.

A controller issues one command per cycle through a valid/ready handshake. The commands are: insert an event, pop the head, delete the first entry of a given type, and look up the target count of a given type. Storage is a sorted register array that shifts on every change. An insert finds its slot with one comparator per entry and completes in a single cycle. Error and warning conditions come out as one-cycle pulses, and a synchronous clear empties the whole queue.

Top module: `timed_event_queue`

## Requirements
- R1: The queue holds at most DEPTH (default 16) entries. An insert while the queue is full leaves the contents unchanged, and `ovf_err` pulses high for the one cycle that follows the accepting clock edge.
- R2: Entries are ordered by the unsigned modular distance `(count - ref)` mod 2^32, smallest first. `ref` equals `now_count - cycle_ofs` when the signed `cycle_ofs` is greater than zero, and equals `now_count` otherwise.
- R3: A new event whose count equals the counts of entries already queued is placed after all of those entries.
- R4: Inserting a type code that is already queued still stores the new entry, and `dup_warn` pulses high for the cycle after the edge.
- R5: A lookup raises `find_done` for the following cycle. In that same cycle `find_count` shows the count of the matching entry nearest the head, or 0 when no entry has that type.
- R6: A delete removes only the matching entry nearest the head. When no entry matches, or the queue is empty, it changes nothing.
- R7: A pop removes the head entry. After the edge, `head_type` and `head_count` show the new head, or 0 when the queue is now empty. A pop on an empty queue has no effect.
- R8: While `clr` is high, `cmd_ready` is low. The clock edge empties the queue, and while the queue is empty `empty` is 1 and both head outputs read 0.
- R9: A command is accepted only on a clock edge where `cmd_valid` and `cmd_ready` are both high. The `cmd_op` encoding is 0 insert, 1 pop, 2 delete and 3 lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all entries |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 2 | 0 insert, 1 pop, 2 delete, 3 lookup |
| cmd_type | input | TYPE_W | Type code for insert, delete and lookup |
| cmd_count | input | CNT_W | Target count for insert |
| now_count | input | CNT_W | Live free-running count |
| cycle_ofs | input | CNT_W | Signed offset subtracted from the count when positive |
| head_type | output | TYPE_W | Type of the earliest entry, 0 when empty |
| head_count | output | CNT_W | Count of the earliest entry, 0 when empty |
| empty | output | 1 | No entries held |
| find_count | output | CNT_W | Lookup result |
| find_done | output | 1 | Lookup result valid pulse |
| ovf_err | output | 1 | Insert dropped because the queue was full |
| dup_warn | output | 1 | Inserted type was already present |

## Verification
The properties assume that `cmd_op` is always one of the four defined codes and that `cmd_valid` stays low during reset, so every pulse has a matching accepted command one cycle earlier. The sorted-order checks also assume the reference count does not move between inserts within one test. The stimulus therefore holds `now_count` and `cycle_ofs` fixed for each sequence and changes them only after a clear. Any change to the offset or the count is made away from the clock edge.

// File: rtl/evq_pkg.sv
package evq_pkg;
   typedef enum logic [1:0] {
      OP_INSERT = 2'd0,
      OP_POP    = 2'd1,
      OP_DELETE = 2'd2,
      OP_LOOKUP = 2'd3
   } evq_op_e;
endpackage

// File: rtl/evq_ref_sel.sv
// Forms the reference count used for distance ordering.
module evq_ref_sel #(
   parameter int CNT_W  = 32,
   parameter bit OFS_EN = 1'b1
) (
   input  logic [CNT_W-1:0] now_count,
   input  logic [CNT_W-1:0] cycle_ofs,
   output logic [CNT_W-1:0] ref_count
);
   generate
      if (OFS_EN) begin : g_ofs
         logic ofs_pos;
         // positive means sign bit clear and nonzero
         assign ofs_pos   = !cycle_ofs[CNT_W-1] && (cycle_ofs != '0);
         assign ref_count = ofs_pos ? (now_count - cycle_ofs) : now_count;
      end else begin : g_plain
         logic [CNT_W-1:0] unused_ofs;
         assign unused_ofs = cycle_ofs;
         assign ref_count  = now_count;
      end
   endgenerate
endmodule

// File: rtl/evq_first_set.sv
// Lowest-index set bit of a request vector.
module evq_first_set #(
   parameter int N  = 16,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/evq_order_cmp.sv
// One comparator per slot: is the new event due strictly before slot i?
module evq_order_cmp #(
   parameter int N     = 16,
   parameter int CNT_W = 32
) (
   input  logic [CNT_W-1:0] ref_count,
   input  logic [CNT_W-1:0] new_count,
   input  logic [CNT_W-1:0] slot_count [N],
   input  logic [N-1:0]     slot_valid,
   output logic [N-1:0]     new_before
);
   logic [CNT_W-1:0] new_dist;
   assign new_dist = new_count - ref_count;

   generate
      for (genvar i = 0; i < N; i++) begin : g_slot
         logic [CNT_W-1:0] slot_dist;
         assign slot_dist     = slot_count[i] - ref_count;
         // equal distance is not "before", so equal counts queue behind
         assign new_before[i] = slot_valid[i] && (new_dist < slot_dist);
      end
   endgenerate
endmodule

// File: rtl/evq_shift_store.sv
// Sorted register array with one-cycle shift-in and shift-out.
module evq_shift_store #(
   parameter int N      = 16,
   parameter int TYPE_W = 4,
   parameter int CNT_W  = 32,
   localparam int IW = (N > 1) ? $clog2(N) : 1,
   localparam int FW = $clog2(N + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ins_en,
   input  logic [IW-1:0]     ins_pos,
   input  logic [TYPE_W-1:0] ins_type,
   input  logic [CNT_W-1:0]  ins_count,
   input  logic              rem_en,
   input  logic [IW-1:0]     rem_pos,
   output logic [TYPE_W-1:0] slot_type  [N],
   output logic [CNT_W-1:0]  slot_count [N],
   output logic [N-1:0]      slot_valid,
   output logic [FW-1:0]     fill
);
   logic [TYPE_W-1:0] nxt_type  [N];
   logic [CNT_W-1:0]  nxt_count [N];

   generate
      for (genvar i = 0; i < N; i++) begin : g_slot
         localparam logic [IW-1:0] SLOT = IW'(i);
         assign slot_valid[i] = (FW'(i) < fill);

         always_comb begin
            nxt_type[i]  = slot_type[i];
            nxt_count[i] = slot_count[i];
            if (ins_en) begin
               if (SLOT == ins_pos) begin
                  nxt_type[i]  = ins_type;
                  nxt_count[i] = ins_count;
               end else if (SLOT > ins_pos) begin
                  if (i > 0) begin
                     nxt_type[i]  = slot_type[(i > 0) ? i - 1 : 0];
                     nxt_count[i] = slot_count[(i > 0) ? i - 1 : 0];
                  end
               end
            end else if (rem_en && (SLOT >= rem_pos)) begin
               if (i == N - 1) begin
                  nxt_type[i]  = '0;
                  nxt_count[i] = '0;
               end else begin
                  nxt_type[i]  = slot_type[(i < N - 1) ? i + 1 : i];
                  nxt_count[i] = slot_count[(i < N - 1) ? i + 1 : i];
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_type[i]  <= '0;
               slot_count[i] <= '0;
            end else if (!clr) begin
               slot_type[i]  <= nxt_type[i];
               slot_count[i] <= nxt_count[i];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
      end else if (clr) begin
         fill <= '0;
      end else if (ins_en) begin
         fill <= fill + FW'(1);
      end else if (rem_en) begin
         fill <= fill - FW'(1);
      end
   end
endmodule

// File: rtl/timed_event_queue.sv
module timed_event_queue #(
   parameter int DEPTH  = 16,
   parameter int TYPE_W = 4,
   parameter int CNT_W  = 32,
   parameter bit OFS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic [TYPE_W-1:0] cmd_type,
   input  logic [CNT_W-1:0]  cmd_count,
   input  logic [CNT_W-1:0]  now_count,
   input  logic [CNT_W-1:0]  cycle_ofs,
   output logic [TYPE_W-1:0] head_type,
   output logic [CNT_W-1:0]  head_count,
   output logic              empty,
   output logic [CNT_W-1:0]  find_count,
   output logic              find_done,
   output logic              ovf_err,
   output logic              dup_warn
);
   import evq_pkg::*;

   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int FW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("timed_event_queue: DEPTH must be at least 2");
      end
      if (TYPE_W < 1) begin : g_bad_type
         $error("timed_event_queue: TYPE_W must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("timed_event_queue: CNT_W must be at least 2");
      end
   endgenerate

   logic [TYPE_W-1:0] slot_type  [DEPTH];
   logic [CNT_W-1:0]  slot_count [DEPTH];
   logic [DEPTH-1:0]  slot_valid;
   logic [FW-1:0]     fill;
   logic [CNT_W-1:0]  ref_count;
   logic [DEPTH-1:0]  new_before;
   logic [DEPTH-1:0]  type_hit;
   logic              before_found;
   logic [IW-1:0]     before_idx;
   logic              hit_found;
   logic [IW-1:0]     hit_idx;
   logic              full;
   logic              fire;
   evq_op_e           op;
   logic              ins_cmd, ins_en, pop_en, del_en, rem_en, look_cmd;
   logic [IW-1:0]     ins_pos, rem_pos;

   assign op        = evq_op_e'(cmd_op);
   assign cmd_ready = !clr;
   assign fire      = cmd_valid && cmd_ready;
   assign full      = (fill == FW'(DEPTH));
   assign empty     = (fill == '0);

   evq_ref_sel #(.CNT_W(CNT_W), .OFS_EN(OFS_EN)) u_ref (
      .now_count (now_count),
      .cycle_ofs (cycle_ofs),
      .ref_count (ref_count)
   );

   evq_order_cmp #(.N(DEPTH), .CNT_W(CNT_W)) u_cmp (
      .ref_count  (ref_count),
      .new_count  (cmd_count),
      .slot_count (slot_count),
      .slot_valid (slot_valid),
      .new_before (new_before)
   );

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_hit
         assign type_hit[i] = slot_valid[i] && (slot_type[i] == cmd_type);
      end
   endgenerate

   evq_first_set #(.N(DEPTH)) u_pos (
      .req   (new_before),
      .found (before_found),
      .idx   (before_idx)
   );

   evq_first_set #(.N(DEPTH)) u_hit (
      .req   (type_hit),
      .found (hit_found),
      .idx   (hit_idx)
   );

   assign ins_cmd  = fire && (op == OP_INSERT);
   assign ins_en   = ins_cmd && !full;
   assign pop_en   = fire && (op == OP_POP) && !empty;
   assign del_en   = fire && (op == OP_DELETE) && hit_found;
   assign look_cmd = fire && (op == OP_LOOKUP);
   assign rem_en   = pop_en || del_en;
   // no earlier-due slot found: append behind the last valid entry
   assign ins_pos  = before_found ? before_idx : fill[IW-1:0];
   assign rem_pos  = pop_en ? '0 : hit_idx;

   evq_shift_store #(.N(DEPTH), .TYPE_W(TYPE_W), .CNT_W(CNT_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .ins_en     (ins_en),
      .ins_pos    (ins_pos),
      .ins_type   (cmd_type),
      .ins_count  (cmd_count),
      .rem_en     (rem_en),
      .rem_pos    (rem_pos),
      .slot_type  (slot_type),
      .slot_count (slot_count),
      .slot_valid (slot_valid),
      .fill       (fill)
   );

   assign head_type  = empty ? '0 : slot_type[0];
   assign head_count = empty ? '0 : slot_count[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         find_count <= '0;
         find_done  <= 1'b0;
         ovf_err    <= 1'b0;
         dup_warn   <= 1'b0;
      end else begin
         find_done <= look_cmd;
         ovf_err   <= ins_cmd && full;
         dup_warn  <= ins_cmd && hit_found;
         if (look_cmd) begin
            find_count <= hit_found ? slot_count[hit_idx] : '0;
         end
      end
   end
endmodule

// File: rtl/timed_event_queue_chk.sv
module timed_event_queue_chk #(
   parameter int DEPTH  = 16,
   parameter int TYPE_W = 4,
   parameter int CNT_W  = 32,
   localparam int FW = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [1:0]        cmd_op,
   input logic [TYPE_W-1:0] head_type,
   input logic [CNT_W-1:0]  head_count,
   input logic              empty,
   input logic              find_done,
   input logic              ovf_err,
   input logic              dup_warn,
   input logic [FW-1:0]     fill
);
   logic acc_ins, acc_pop, acc_look;
   assign acc_ins  = cmd_valid && cmd_ready && (cmd_op == 2'd0);
   assign acc_pop  = cmd_valid && cmd_ready && (cmd_op == 2'd1);
   assign acc_look = cmd_valid && cmd_ready && (cmd_op == 2'd3);

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FW'(DEPTH));

   assert_drop_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ins && fill == FW'(DEPTH)) |=> (ovf_err && fill == FW'(DEPTH)));

   assert_insert_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ins && fill < FW'(DEPTH)) |=> (!ovf_err && fill == $past(fill) + FW'(1)));

   assert_dup_after_insert_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dup_warn |-> $past(acc_ins));

   assert_find_after_lookup_R5: assert property (@(posedge clk) disable iff (!rst_n)
      find_done |-> $past(acc_look));

   assert_pop_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_pop && !empty) |=> (fill == $past(fill) - FW'(1)));

   assert_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_pop && empty) |=> empty);

   assert_empty_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (head_type == '0 && head_count == '0));

   assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);

   assert_clear_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> !cmd_ready);
endmodule

bind timed_event_queue timed_event_queue_chk #(
   .DEPTH(DEPTH), .TYPE_W(TYPE_W), .CNT_W(CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr        (clr),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .cmd_op     (cmd_op),
   .head_type  (head_type),
   .head_count (head_count),
   .empty      (empty),
   .find_done  (find_done),
   .ovf_err    (ovf_err),
   .dup_warn   (dup_warn),
   .fill       (fill)
);

// File: tb/sim_timed_event_queue.sv
module sim_timed_event_queue;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 16;
   localparam int TYPE_W = 4;
   localparam int CNT_W  = 32;
   localparam int NVEC   = 10;
   localparam int VW     = 2 + TYPE_W + CNT_W + TYPE_W + CNT_W + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clr = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_ready;
   logic [1:0]        cmd_op = '0;
   logic [TYPE_W-1:0] cmd_type = '0;
   logic [CNT_W-1:0]  cmd_count = '0;
   logic [CNT_W-1:0]  now_count = '0;
   logic [CNT_W-1:0]  cycle_ofs = '0;
   logic [TYPE_W-1:0] head_type;
   logic [CNT_W-1:0]  head_count;
   logic              empty;
   logic [CNT_W-1:0]  find_count;
   logic              find_done;
   logic              ovf_err;
   logic              dup_warn;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   timed_event_queue #(.DEPTH(DEPTH), .TYPE_W(TYPE_W), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_type(cmd_type),
      .cmd_count(cmd_count), .now_count(now_count), .cycle_ofs(cycle_ofs),
      .head_type(head_type), .head_count(head_count), .empty(empty),
      .find_count(find_count), .find_done(find_done), .ovf_err(ovf_err),
      .dup_warn(dup_warn)
   );

   // {op, type, count, expected head type, expected head count, expected empty}
   // R2 ordering with now_count = 100: targets 50 and 0xFFFFFFF0 lie behind
   // the reference and so wrap to the far end; R7 pops drain to empty.
   localparam logic [VW-1:0] VEC [NVEC] = '{
      {2'd0, 4'd1, 32'd500,        4'd1, 32'd500, 1'b0},
      {2'd0, 4'd2, 32'd300,        4'd2, 32'd300, 1'b0},
      {2'd0, 4'd3, 32'd50,         4'd2, 32'd300, 1'b0},
      {2'd0, 4'd4, 32'hFFFF_FFF0,  4'd2, 32'd300, 1'b0},
      {2'd0, 4'd5, 32'd150,        4'd5, 32'd150, 1'b0},
      {2'd1, 4'd0, 32'd0,          4'd2, 32'd300, 1'b0},
      {2'd1, 4'd0, 32'd0,          4'd1, 32'd500, 1'b0},
      {2'd1, 4'd0, 32'd0,          4'd4, 32'hFFFF_FFF0, 1'b0},
      {2'd1, 4'd0, 32'd0,          4'd3, 32'd50, 1'b0},
      {2'd1, 4'd0, 32'd0,          4'd0, 32'd0, 1'b1}
   };

   task automatic check(input string tag, input logic [CNT_W-1:0] act,
                        input logic [CNT_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [1:0] op, input logic [TYPE_W-1:0] ty,
                        input logic [CNT_W-1:0] ct);
      cmd_op    = op;
      cmd_type  = ty;
      cmd_count = ct;
      cmd_valid = 1'b1;
      @(posedge clk);
      #1;
      cmd_valid = 1'b0;
   endtask

   task automatic do_clear();
      clr = 1'b1;
      @(posedge clk);
      #1;
      clr = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      // R8 reset state
      check("R8 empty after reset", 32'(empty), 32'd1);
      check("R8 head type after reset", 32'(head_type), 32'd0);
      check("R8 head count after reset", head_count, 32'd0);
      check("R8 ready after reset", 32'(cmd_ready), 32'd1);

      // R2 / R7 vector walk
      now_count = 32'd100;
      for (int v = 0; v < NVEC; v++) begin
         logic [VW-1:0] e;
         e = VEC[v];
         issue(e[VW-1 -: 2], e[VW-3 -: TYPE_W], e[VW-3-TYPE_W -: CNT_W]);
         check($sformatf("R2 R7 vec %0d head type", v), 32'(head_type),
               32'(e[CNT_W+1 +: TYPE_W]));
         check($sformatf("R2 R7 vec %0d head count", v), head_count,
               e[1 +: CNT_W]);
         check($sformatf("R2 R7 vec %0d empty", v), 32'(empty), 32'(e[0]));
      end

      // R3 equal counts keep insertion order
      issue(2'd0, 4'd1, 32'd200);
      issue(2'd0, 4'd2, 32'd200);
      issue(2'd0, 4'd3, 32'd200);
      check("R3 first equal at head", 32'(head_type), 32'd1);
      issue(2'd1, 4'd0, 32'd0);
      check("R3 second equal next", 32'(head_type), 32'd2);
      issue(2'd1, 4'd0, 32'd0);
      check("R3 third equal last", 32'(head_type), 32'd3);
      issue(2'd1, 4'd0, 32'd0);
      check("R7 empty after drain", 32'(empty), 32'd1);

      // R4 duplicate type; R5 lookup; R6 delete
      issue(2'd0, 4'd6, 32'd400);
      check("R4 no warn on first", 32'(dup_warn), 32'd0);
      issue(2'd0, 4'd6, 32'd250);
      check("R4 warn on duplicate", 32'(dup_warn), 32'd1);
      check("R4 duplicate stored at head", head_count, 32'd250);
      issue(2'd3, 4'd6, 32'd0);
      check("R5 lookup done", 32'(find_done), 32'd1);
      check("R5 lookup nearest head", find_count, 32'd250);
      issue(2'd3, 4'd9, 32'd0);
      check("R5 lookup miss done", 32'(find_done), 32'd1);
      check("R5 lookup miss zero", find_count, 32'd0);
      issue(2'd2, 4'd9, 32'd0);
      check("R6 delete miss keeps head", head_count, 32'd250);
      issue(2'd2, 4'd6, 32'd0);
      check("R6 delete removes first only", head_count, 32'd400);
      check("R6 delete keeps other", 32'(empty), 32'd0);
      issue(2'd1, 4'd0, 32'd0);
      check("R7 pop last to empty", 32'(empty), 32'd1);
      issue(2'd2, 4'd6, 32'd0);
      check("R6 delete on empty", 32'(empty), 32'd1);
      issue(2'd1, 4'd0, 32'd0);
      check("R7 pop on empty", 32'(empty), 32'd1);
      check("R7 head zero on empty", head_count, 32'd0);

      // R9 command without valid is ignored
      cmd_op = 2'd0; cmd_type = 4'd7; cmd_count = 32'd123;
      @(posedge clk);
      #1;
      check("R9 no valid no insert", 32'(empty), 32'd1);

      // R2 positive offset: reference 1000-600=400, so 900 due before 300
      do_clear();
      now_count = 32'd1000;
      cycle_ofs = 32'd600;
      issue(2'd0, 4'd10, 32'd300);
      issue(2'd0, 4'd11, 32'd900);
      check("R2 positive offset order", 32'(head_type), 32'd11);
      // R2 negative offset is ignored: reference 1000, 300 due first
      do_clear();
      cycle_ofs = -32'sd600;
      issue(2'd0, 4'd10, 32'd300);
      issue(2'd0, 4'd11, 32'd900);
      check("R2 negative offset ignored", 32'(head_type), 32'd10);

      // R1 capacity
      do_clear();
      now_count = 32'd0;
      cycle_ofs = 32'd0;
      for (int i = 0; i < DEPTH; i++) begin
         issue(2'd0, TYPE_W'(i), 32'(1000 + i));
         check($sformatf("R1 fill insert %0d no ovf", i), 32'(ovf_err), 32'd0);
      end
      issue(2'd0, 4'd15, 32'd5);
      check("R1 overflow pulse", 32'(ovf_err), 32'd1);
      check("R1 dropped insert leaves head", head_count, 32'd1000);
      @(posedge clk);
      #1;
      check("R1 overflow pulse one cycle", 32'(ovf_err), 32'd0);
      for (int i = 0; i < DEPTH; i++) begin
         check($sformatf("R1 drain %0d", i), head_count, 32'(1000 + i));
         issue(2'd1, 4'd0, 32'd0);
      end
      check("R1 empty after full drain", 32'(empty), 32'd1);

      // R8 clear wins over a command and empties
      issue(2'd0, 4'd2, 32'd77);
      clr = 1'b1;
      cmd_valid = 1'b1; cmd_op = 2'd0; cmd_type = 4'd3; cmd_count = 32'd88;
      #1;
      check("R8 ready low in clear", 32'(cmd_ready), 32'd0);
      @(posedge clk);
      #1;
      clr = 1'b0;
      cmd_valid = 1'b0;
      check("R8 clear empties", 32'(empty), 32'd1);
      check("R8 head zero after clear", head_count, 32'd0);

      summary();
   end
endmodule